// File: doc/BRIEF.md
# Flash Program/Erase Busy and Status Engine

This block stands in for the internally timed part of a word-wide flash memory on a synchronous bus. A host starts a word program with an address and a data word, or starts an erase with a mask of regions. The engine then stays busy for a fixed number of clock cycles and updates its small word array when that time runs out. It does not decode command sequences. Program and erase durations are cycle-count parameters, not real time.

While the engine is busy, a read does not return array contents. It returns a synthesised status word. Bit 7 reports whether the operation has finished, and bit 6 flips on every read. A host can therefore poll for completion with either bit.

Every clock edge at which the active-low reset is low halts the operation. If a word program is cut short this way, the target word is left holding a fixed marker pattern. After reset, word programs are refused for a power-up window, and erases are still accepted during that window.

Top module: `flash_busy_engine`

## Requirements
- R1: At a clock edge where `rst_n` is low, the engine drops any running operation. In the following cycle `busy`, `done` and `rd_valid` are 0. When `rst_n` is high again, the engine is idle and reads return array data.
- R2: When the engine is idle and not locked out, a `prog_req` without `erase_req` is accepted. `busy` is then high for exactly `PROG_CYC` cycles, starting the cycle after the request. The addressed word then holds the bitwise AND of its old value and the new data.
- R3: When idle, an `erase_req` is accepted even during the lockout window. If `prog_req` is present at the same time, the erase wins. `busy` is then high for exactly `ERASE_CYC` cycles. Afterwards, every word whose region bit is set in `erase_mask` reads all ones, and every other word is unchanged. A word's region is its top log2(`NREG`) address bits, so bit r of the mask selects region r.
- R4: `done` is high for exactly one cycle: the first cycle in which `busy` is low after an operation has completed.
- R5: A `rd_req` returns a result in the next cycle, with `rd_valid` high. When the engine is idle, `rdata` is the array word at `rd_addr`.
- R6: A read accepted while a word program is busy returns the complement of bit 7 of the data being written on bit 7. All other bits except bit 6 read 0.
- R7: A read accepted while an erase is busy returns 0 on bit 7 and on every bit other than bit 6.
- R8: Bit 6 of successive busy reads alternates. After completion, repeated reads of one word return the same true data.
- R9: While the engine is busy, `prog_req` and `erase_req` are ignored. They do not change the timing or the array.
- R10: A reset that halts a word program leaves that word holding `CORRUPT`, which is 16'hDEAD by default.
- R11: For `PWRUP_CYC` cycles after reset is released, `prog_req` is ignored and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; halts any running operation |
| prog_req | input | 1 | Start a word program |
| prog_addr | input | AW | Word address to program |
| prog_data | input | DW | Data to program (AND-ed into the stored word) |
| erase_req | input | 1 | Start an erase |
| erase_mask | input | NREG | One bit per region to erase |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rdata | output | DW | Read result: array word or busy status |
| rd_valid | output | 1 | `rdata` holds the result of last cycle's read |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with a 16-word array in four regions, a 6-cycle program, a 10-cycle erase and a 12-cycle power-up window. With these values, every word can be checked after an erase, and a region boundary falls at address 4. Several status reads fit inside a single busy period, together with a request that must be dropped. The bench also measures the exact busy length, and it checks the lockout both right after reset and after a mid-program reset.

// File: rtl/flash_busy_engine.sv
module flash_busy_engine #(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int NREG      = 4,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 200,
  parameter int PWRUP_CYC = 100,
  parameter logic [DW-1:0] CORRUPT = 16'hDEAD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_req,
  input  logic [AW-1:0]   prog_addr,
  input  logic [DW-1:0]   prog_data,
  input  logic            erase_req,
  input  logic [NREG-1:0] erase_mask,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rdata,
  output logic            rd_valid,
  output logic            busy,
  output logic            done
);
  localparam int DEPTH = 1 << AW;
  localparam int RB    = $clog2(NREG);
  localparam int TMAX  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = $clog2(TMAX + 1);
  localparam int LW    = $clog2(PWRUP_CYC + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic            busy_q, erase_op, done_q, tog_q, vld_q;
  logic [CW-1:0]   cnt_q;
  logic [LW-1:0]   lock_q;
  logic [AW-1:0]   tgt_a;
  logic [DW-1:0]   tgt_d;
  logic [NREG-1:0] tgt_m;
  logic [DW-1:0]   rd_q;
  logic [DW-1:0]   stat;

  wire start_er = !busy_q && erase_req;
  wire start_pg = !busy_q && prog_req && !erase_req && (lock_q == '0);

  always_comb begin
    stat    = '0;
    stat[7] = erase_op ? 1'b0 : ~tgt_d[7];
    stat[6] = tog_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (busy_q && !erase_op) mem[tgt_a] <= CORRUPT;
      busy_q   <= 1'b0;
      erase_op <= 1'b0;
      done_q   <= 1'b0;
      vld_q    <= 1'b0;
      tog_q    <= 1'b0;
      rd_q     <= '0;
      cnt_q    <= '0;
      lock_q   <= LW'(PWRUP_CYC);
    end else begin
      done_q <= 1'b0;
      vld_q  <= rd_req;
      if (lock_q != '0) lock_q <= lock_q - 1'b1;
      if (rd_req) begin
        if (busy_q) begin
          rd_q  <= stat;
          tog_q <= ~tog_q;
        end else begin
          rd_q <= mem[rd_addr];
        end
      end
      if (start_er) begin
        busy_q   <= 1'b1;
        erase_op <= 1'b1;
        tgt_m    <= erase_mask;
        cnt_q    <= CW'(ERASE_CYC - 1);
      end else if (start_pg) begin
        busy_q   <= 1'b1;
        erase_op <= 1'b0;
        tgt_a    <= prog_addr;
        tgt_d    <= prog_data;
        cnt_q    <= CW'(PROG_CYC - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (erase_op) begin
            for (int i = 0; i < DEPTH; i++)
              if (tgt_m[RB'(i >> (AW - RB))]) mem[i] <= '1;
          end else begin
            mem[tgt_a] <= mem[tgt_a] & tgt_d;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rdata    = rd_q;
  assign rd_valid = vld_q;
  assign busy     = busy_q;
  assign done     = done_q;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);
  assert_drop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> ($stable(tgt_a) && $stable(tgt_d) && $stable(erase_op)));
  assert_lockout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0 && prog_req && !erase_req && !busy_q) |=> !busy_q);
  assert_erase_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy_q && erase_op) |=> (rdata[7] == 1'b0));
  assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
endmodule

// File: tb/tb_flash_busy_engine.sv
module tb_flash_busy_engine;
  localparam int AW = 4, DW = 16, NREG = 4, PC = 6, EC = 10, PU = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_req = 1'b0, erase_req = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic [NREG-1:0] erase_mask = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, busy, done;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  flash_busy_engine #(.AW(AW), .DW(DW), .NREG(NREG), .PROG_CYC(PC),
    .ERASE_CYC(EC), .PWRUP_CYC(PU), .CORRUPT(16'hDEAD)) dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_mask(erase_mask),
    .rd_req(rd_req), .rd_addr(rd_addr), .rdata(rdata), .rd_valid(rd_valid),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    d = rdata;
    chk(rd_valid == 1'b1, "R5 rd_valid", {31'b0, rd_valid}, 1);
  endtask

  task automatic start_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    prog_req = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic start_erase(input logic [NREG-1:0] m);
    erase_req = 1'b1; erase_mask = m;
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(done == 1'b1, "R4 done high", {31'b0, done}, 1);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single", {31'b0, done}, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rd_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && rd_valid == 0, "R1 reset outputs",
        {29'b0, busy, done, rd_valid}, 0);
    rd_req = 1'b0; rst_n = 1'b1;
  endtask

  task automatic t_lockout_erase;
    logic [DW-1:0] d1, d2;
    int n;
    start_prog(3, 16'h0000);
    chk(busy == 0, "R11 prog in lockout", {31'b0, busy}, 0);
    start_erase('1);
    chk(busy == 1, "R3 erase in lockout", {31'b0, busy}, 1);
    rd(0, d1);
    rd(7, d2);
    chk((d1 & ~16'h0040) == 0, "R7 erase status", d1, 0);
    chk((d2 & ~16'h0040) == 0, "R7 erase status 2", d2, 0);
    chk(d1[6] != d2[6], "R8 toggle erase", d2, ~d1);
    wait_done(n);
    chk(n == EC - 2, "R3 erase length", n, EC - 2);
    for (int i = 0; i < (1 << AW); i++) begin
      rd(AW'(i), d1);
      chk(d1 == 16'hFFFF, "R3 erased word", d1, 16'hFFFF);
    end
    repeat (PU) @(negedge clk);
  endtask

  task automatic t_program;
    logic [DW-1:0] d;
    int n;
    start_prog(5, 16'h12B4);
    wait_done(n);
    chk(n == PC, "R2 program length", n, PC);
    rd(5, d);
    chk(d == 16'h12B4, "R2 program data", d, 16'h12B4);
  endtask

  task automatic t_status_drop;
    logic [DW-1:0] d1, d2;
    int n;
    start_prog(5, 16'hFF0F);
    rd(1, d1);
    rd(1, d2);
    chk((d1 & ~16'h0040) == 16'h0080, "R6 program status", d1, 16'h0080);
    chk(d1[6] != d2[6], "R8 toggle program", d2, ~d1);
    prog_req = 1'b1; prog_addr = 9; prog_data = 16'h0000;
    erase_req = 1'b1; erase_mask = '1;
    @(negedge clk);
    prog_req = 1'b0; erase_req = 1'b0;
    wait_done(n);
    chk(n == PC - 3, "R9 timing unchanged", n, PC - 3);
    rd(5, d1);
    chk(d1 == 16'h1204, "R2 AND into word", d1, 16'h1204);
    rd(9, d1);
    chk(d1 == 16'hFFFF, "R9 dropped request", d1, 16'hFFFF);
    rd(5, d1);
    rd(5, d2);
    chk(d1 == d2 && d2 == 16'h1204, "R8 stable after done", d2, 16'h1204);
  endtask

  task automatic t_sector;
    logic [DW-1:0] d;
    int n;
    start_prog(0, 16'h00F0);
    wait_done(n);
    start_erase(4'b0010);
    wait_done(n);
    chk(n == EC, "R3 sector erase length", n, EC);
    rd(5, d);
    chk(d == 16'hFFFF, "R3 region erased", d, 16'hFFFF);
    rd(0, d);
    chk(d == 16'h00F0, "R3 other region kept", d, 16'h00F0);
  endtask

  task automatic t_corrupt;
    logic [DW-1:0] d;
    start_prog(2, 16'h5555);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && rd_valid == 0, "R1 halt outputs",
        {29'b0, busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    rd(2, d);
    chk(d == 16'hDEAD, "R10 corrupted word", d, 16'hDEAD);
    start_prog(3, 16'h0000);
    chk(busy == 0, "R11 relock after reset", {31'b0, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lockout_erase();
    t_program();
    t_status_drop();
    t_sector();
    t_corrupt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule